// File: doc/BRIEF.md
# GPIB Inbound Word Tagger with Transfer Termination

This block sits between the acceptor handshake of a GPIB interface and its inbound FIFO. Each time the handshake offers a received data byte or a secondary address, the block decides whether the byte can be taken. If it can, the block builds a 16-bit FIFO word: a two-bit tag in bits 15:14 and the payload in the low bits. If it cannot, it tells the handshake to hold off. The FIFO storage and the handshake itself are outside the block.

While the interface is the controller and watches a byte transfer between other devices, the block also reads the byte-transfer-enable word at the head of the outbound queue. It ends that transfer on EOI, on a line feed unless line-feed detection is inhibited, or when the programmed byte count runs out. It then pops the enable word and clears its byte counter. Every request gets a registered response one clock later.

Top module: `rx_tagger`

## Requirements
- R1: After a synchronous reset every output is low and the byte counter is zero, so a counted transfer with count field N ends on the N-th accepted byte.
- R2: A stored data byte without EOI and without a termination match carries tag 00. A data byte received with EOI carries tag 11.
- R3: While monitoring, a byte equal to 0x0A ends the transfer with tag 11 when bit 15 of the enable word is 0. When bit 15 is 1 the line feed is an ordinary byte.
- R4: While monitoring, when the enable word is not 0xC000 and the counter plus one, modulo 256, equals the enable word's low byte, the byte gets tag 10 and the transfer ends. The value 0xC000 means an uncounted transfer and never expires.
- R5: Ending a transfer pops the enable word (`oq_pop` high for one cycle) and resets the counter to zero. Any other accepted data byte increments the counter. Stalled bytes and secondary addresses leave the counter unchanged.
- R6: Monitoring is active only while the outbound queue is non-empty, `ctrl_send` is high and `talker_active` is low. Without monitoring there is no pop, and a line feed or a count match stays tag 00.
- R7: A secondary address request (`req_kind` = 1) is stored as 0x4000 OR the 5-bit address in `req_byte[4:0]`, with bit 5 set when `talk_addressed` is high. It is stored only when the interface is addressed to talk or listen. Otherwise it is accepted and discarded.
- R8: A data byte (`req_kind` = 0) is stored only while `listen_active` is high. Otherwise it is accepted without a FIFO write, but it still counts and can still end a monitored transfer.
- R9: When `ififo_full` or `dev_clear` is high, a byte that would be stored is refused. The response has `resp_stall` high, and there is no write, no pop, no freeze and no change to the counter.
- R10: Storing a data byte while `talker_active` is low raises `freeze_set` in the same cycle as the write.
- R11: EOI takes priority over line feed, and line feed takes priority over count expiry, when several apply to one byte.
- R12: Every request cycle is followed one clock later by exactly one `resp_valid` pulse. All outputs are registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Handshake offers a byte this cycle |
| req_kind | input | 1 | 0 = data byte, 1 = secondary address |
| req_byte | input | 8 | Received byte, or address in bits 4:0 |
| req_eoi | input | 1 | EOI was asserted with the data byte |
| listen_active | input | 1 | Listener in its active state |
| listen_addressed | input | 1 | Interface addressed to listen |
| talk_addressed | input | 1 | Interface addressed to talk |
| talker_active | input | 1 | Interface is the active talker |
| ctrl_send | input | 1 | Controller in its send-bytes state |
| oq_empty | input | 1 | Outbound queue is empty |
| oq_head | input | 16 | Word at the head of the outbound queue |
| ififo_full | input | 1 | Inbound FIFO full |
| dev_clear | input | 1 | Device-clear flag pending |
| fifo_wr | output | 1 | Write strobe to inbound FIFO |
| fifo_word | output | 16 | Tagged word to write |
| oq_pop | output | 1 | Pop the enable word from the outbound queue |
| resp_valid | output | 1 | Response to the previous cycle's request |
| resp_stall | output | 1 | Request refused; handshake must stall |
| freeze_set | output | 1 | Set the data-freeze status flag |

## Verification
The bench aims at the bytes that hit several terminations at once, such as an EOI line feed on the expiring count. A design with the priority reversed would tag such a byte 10 instead of 11. It targets a line feed under an inhibited enable word and under the uncounted value 0xC000, where a careless decode would either end the transfer early or never stop counting. It also drives stalls in the middle of a counted transfer. A design that counted refused bytes would end the transfer one byte early. A long random run with a free-running reference counter catches a counter that is not cleared on pop, and it also catches a monitor condition that ignores `talker_active`.

// File: rtl/rxt_pkg.sv
package rxt_pkg;
  typedef enum logic [1:0] {
    TAG_DATA = 2'b00,
    TAG_SEC  = 2'b01,
    TAG_CNT  = 2'b10,
    TAG_END  = 2'b11
  } rxt_tag_e;

  typedef struct packed {
    rxt_tag_e tag;
    logic     ends;
  } rxt_term_t;

  localparam logic [7:0] LINE_FEED = 8'h0A;
endpackage

// File: rtl/rxt_byte_counter.sv
module rxt_byte_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (inc)   count <= count + 1'b1;
  end
endmodule

// File: rtl/rxt_term_detect.sv
module rxt_term_detect
  import rxt_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter int          WORD_W     = 16,
  parameter int          CNT_W      = 8,
  parameter int          LF_INH_BIT = 15,
  parameter logic [15:0] UNCNT_WORD = 16'hC000
) (
  input  logic              monitor,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_eoi,
  input  logic [WORD_W-1:0] head,
  input  logic [CNT_W-1:0]  count,
  output rxt_term_t         term
);
  logic [CNT_W-1:0] count_next;
  logic             lf_hit;
  logic             cnt_hit;

  assign count_next = count + 1'b1;
  assign lf_hit  = monitor && !head[LF_INH_BIT] && (rx_byte == DATA_W'(LINE_FEED));
  assign cnt_hit = monitor && (head != WORD_W'(UNCNT_WORD)) &&
                   (count_next == head[CNT_W-1:0]);

  always_comb begin
    term.tag  = TAG_DATA;
    term.ends = 1'b0;
    if (rx_eoi) begin
      term.tag  = TAG_END;
      term.ends = monitor;
    end else if (lf_hit) begin
      term.tag  = TAG_END;
      term.ends = 1'b1;
    end else if (cnt_hit) begin
      term.tag  = TAG_CNT;
      term.ends = 1'b1;
    end
  end
endmodule

// File: rtl/rxt_word_pack.sv
module rxt_word_pack
  import rxt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WORD_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic              is_sec,
  input  rxt_tag_e          data_tag,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              talk_addressed,
  output logic [WORD_W-1:0] word
);
  localparam int PAD_W = WORD_W - 2 - DATA_W;

  logic [WORD_W-1:0] data_word;
  logic [WORD_W-1:0] sec_word;

  generate
    if (PAD_W > 0) begin : g_pad
      assign data_word = {data_tag, {PAD_W{1'b0}}, rx_byte};
    end else begin : g_nopad
      assign data_word = {data_tag, rx_byte};
    end
  endgenerate

  always_comb begin
    sec_word                   = '0;
    sec_word[WORD_W-1 -: 2]    = TAG_SEC;
    sec_word[ADDR_W]           = talk_addressed;
    sec_word[ADDR_W-1:0]       = rx_byte[ADDR_W-1:0];
  end

  assign word = is_sec ? sec_word : data_word;
endmodule

// File: rtl/rx_tagger.sv
module rx_tagger
  import rxt_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter int          WORD_W     = 16,
  parameter int          CNT_W      = 8,
  parameter int          ADDR_W     = 5,
  parameter int          LF_INH_BIT = 15,
  parameter logic [15:0] UNCNT_WORD = 16'hC000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_kind,
  input  logic [DATA_W-1:0] req_byte,
  input  logic              req_eoi,
  input  logic              listen_active,
  input  logic              listen_addressed,
  input  logic              talk_addressed,
  input  logic              talker_active,
  input  logic              ctrl_send,
  input  logic              oq_empty,
  input  logic [WORD_W-1:0] oq_head,
  input  logic              ififo_full,
  input  logic              dev_clear,
  output logic              fifo_wr,
  output logic [WORD_W-1:0] fifo_word,
  output logic              oq_pop,
  output logic              resp_valid,
  output logic              resp_stall,
  output logic              freeze_set
);
  logic             is_data, is_sec, monitor, blocked;
  logic             data_stall, sec_stall, data_acc;
  logic             wr_data, wr_sec, sec_for_us;
  logic             end_xfer;
  logic [CNT_W-1:0] count;
  rxt_term_t        term;
  logic [WORD_W-1:0] word;

  assign is_data    = req_valid && !req_kind;
  assign is_sec     = req_valid &&  req_kind;
  assign monitor    = !oq_empty && ctrl_send && !talker_active;
  assign blocked    = ififo_full || dev_clear;
  assign sec_for_us = talk_addressed || listen_addressed;

  assign data_stall = is_data && listen_active && blocked;
  assign sec_stall  = is_sec && sec_for_us && blocked;
  assign data_acc   = is_data && !data_stall;
  assign wr_data    = data_acc && listen_active;
  assign wr_sec     = is_sec && sec_for_us && !blocked;
  assign end_xfer   = data_acc && term.ends;

  rxt_term_detect #(
    .DATA_W(DATA_W), .WORD_W(WORD_W), .CNT_W(CNT_W),
    .LF_INH_BIT(LF_INH_BIT), .UNCNT_WORD(UNCNT_WORD)
  ) u_term (
    .monitor (monitor),
    .rx_byte (req_byte),
    .rx_eoi  (req_eoi),
    .head    (oq_head),
    .count   (count),
    .term    (term)
  );

  rxt_byte_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .inc   (data_acc && !term.ends),
    .clr   (end_xfer),
    .count (count)
  );

  rxt_word_pack #(.DATA_W(DATA_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_pack (
    .is_sec         (req_kind),
    .data_tag       (term.tag),
    .rx_byte        (req_byte),
    .talk_addressed (talk_addressed),
    .word           (word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_wr    <= 1'b0;
      fifo_word  <= '0;
      oq_pop     <= 1'b0;
      resp_valid <= 1'b0;
      resp_stall <= 1'b0;
      freeze_set <= 1'b0;
    end else begin
      fifo_wr    <= wr_data || wr_sec;
      if (wr_data || wr_sec) fifo_word <= word;
      oq_pop     <= end_xfer;
      resp_valid <= req_valid;
      resp_stall <= data_stall || sec_stall;
      freeze_set <= wr_data && !talker_active;
    end
  end
endmodule

// File: rtl/rx_tagger_chk.sv
module rx_tagger_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_kind,
  input logic              req_eoi,
  input logic              oq_empty,
  input logic              ctrl_send,
  input logic              talker_active,
  input logic              fifo_wr,
  input logic [WORD_W-1:0] fifo_word,
  input logic              oq_pop,
  input logic              resp_valid,
  input logic              resp_stall,
  input logic              freeze_set
);
  p_resp_after_req_r12: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid);
  p_resp_needs_req_r12: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> $past(req_valid));
  p_stall_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    resp_stall |-> (!fifo_wr && !oq_pop && !freeze_set));
  p_pop_monitor_r6: assert property (@(posedge clk) disable iff (rst)
    oq_pop |-> $past(req_valid && !req_kind && !oq_empty && ctrl_send && !talker_active));
  p_eoi_tag_r2: assert property (@(posedge clk) disable iff (rst)
    (fifo_wr && $past(req_valid && !req_kind && req_eoi)) |-> (fifo_word[WORD_W-1 -: 2] == 2'b11));
  p_sec_tag_r7: assert property (@(posedge clk) disable iff (rst)
    (fifo_wr && $past(req_valid && req_kind)) |-> (fifo_word[WORD_W-1 -: 2] == 2'b01));
  p_cnt_pops_r4: assert property (@(posedge clk) disable iff (rst)
    (fifo_wr && fifo_word[WORD_W-1 -: 2] == 2'b10) |-> oq_pop);
  p_freeze_write_r10: assert property (@(posedge clk) disable iff (rst)
    freeze_set |-> (fifo_wr && $past(!talker_active)));
endmodule

bind rx_tagger rx_tagger_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
  .req_eoi(req_eoi), .oq_empty(oq_empty), .ctrl_send(ctrl_send),
  .talker_active(talker_active), .fifo_wr(fifo_wr), .fifo_word(fifo_word),
  .oq_pop(oq_pop), .resp_valid(resp_valid), .resp_stall(resp_stall),
  .freeze_set(freeze_set)
);

// File: tb/rx_tagger_bench.sv
`timescale 1ns/1ps
module rx_tagger_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_kind, req_eoi;
  logic [7:0]  req_byte;
  logic        listen_active, listen_addressed, talk_addressed, talker_active;
  logic        ctrl_send, oq_empty, ififo_full, dev_clear;
  logic [15:0] oq_head;
  logic        fifo_wr, oq_pop, resp_valid, resp_stall, freeze_set;
  logic [15:0] fifo_word;

  int checks = 0;
  int fails  = 0;
  int mcnt   = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  rx_tagger u_rx_tagger (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_byte(req_byte), .req_eoi(req_eoi), .listen_active(listen_active),
    .listen_addressed(listen_addressed), .talk_addressed(talk_addressed),
    .talker_active(talker_active), .ctrl_send(ctrl_send), .oq_empty(oq_empty),
    .oq_head(oq_head), .ififo_full(ififo_full), .dev_clear(dev_clear),
    .fifo_wr(fifo_wr), .fifo_word(fifo_word), .oq_pop(oq_pop),
    .resp_valid(resp_valid), .resp_stall(resp_stall), .freeze_set(freeze_set)
  );

  // Packed expectation: {wr, word, pop, rvalid, stall, freeze}
  function automatic logic [20:0] observed();
    return {fifo_wr, (fifo_wr ? fifo_word : 16'h0), oq_pop, resp_valid, resp_stall, freeze_set};
  endfunction

  task automatic chk(input string tag, input logic [20:0] act, input logic [20:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model from the requirements; updates mcnt
  function automatic logic [20:0] model(output string tag);
    logic mon, blk, stall, acc, wr, pop, frz, ends;
    logic [1:0] t;
    logic [15:0] w;
    tag = "R2";
    mon = !oq_empty && ctrl_send && !talker_active;          // R6
    blk = ififo_full || dev_clear;
    w = 16'h0; wr = 0; pop = 0; frz = 0; stall = 0;
    if (req_kind) begin                                        // R7
      tag = "R7";
      if (talk_addressed || listen_addressed) begin
        if (blk) begin stall = 1; tag = "R9"; end
        else begin wr = 1; w = 16'h4000 | {10'h0, talk_addressed, req_byte[4:0]}; end
      end
    end else begin
      stall = listen_active && blk;                            // R9
      acc = !stall;
      t = 2'b00; ends = 0;
      if (req_eoi) begin t = 2'b11; ends = mon; tag = "R11"; end
      else if (mon && !oq_head[15] && req_byte == 8'h0A) begin t = 2'b11; ends = 1; tag = "R3"; end
      else if (mon && oq_head != 16'hC000 && ((mcnt + 1) % 256) == oq_head[7:0]) begin
        t = 2'b10; ends = 1; tag = "R4";
      end
      if (stall) tag = "R9";
      else if (!listen_active) tag = "R8";
      if (acc) begin                                           // R5
        pop = ends;
        mcnt = ends ? 0 : (mcnt + 1) % 256;
        if (listen_active) begin
          wr = 1; w = {t, 6'h0, req_byte};
          frz = !talker_active;                                // R10
        end
      end
    end
    return {wr, w, pop, 1'b1, stall, frz};                     // R12
  endfunction

  task automatic set_env(input bit la, input bit laddr, input bit taddr, input bit tact,
                         input bit cs, input bit oe, input logic [15:0] hd,
                         input bit full, input bit dc);
    listen_active = la; listen_addressed = laddr; talk_addressed = taddr;
    talker_active = tact; ctrl_send = cs; oq_empty = oe; oq_head = hd;
    ififo_full = full; dev_clear = dc;
  endtask

  task automatic do_req(input bit kind, input logic [7:0] b, input bit eoi);
    logic [20:0] exp;
    string tag;
    req_valid = 1; req_kind = kind; req_byte = b; req_eoi = eoi;
    exp = model(tag);
    @(negedge clk);
    req_valid = 0;
    chk(tag, observed(), exp);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    rst = 1; req_valid = 0; req_kind = 0; req_byte = 0; req_eoi = 0;
    set_env(1, 1, 0, 0, 1, 0, 16'h0003, 0, 0);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state quiet
    chk("R1", observed(), 21'h0);
    // R1 / R4: count 3 expires on third byte after reset
    do_req(0, 8'h11, 0);
    do_req(0, 8'h22, 0);
    do_req(0, 8'h33, 0);
    chk("R4", {20'h0, mcnt == 0}, 21'h1);
    // R11: EOI + LF + expiring count -> tag 11 and pop
    set_env(1, 1, 0, 0, 1, 0, 16'h0001, 0, 0);
    do_req(0, 8'h0A, 1);
    // R11: LF + expiring count -> tag 11
    do_req(0, 8'h0A, 0);
    // R3: inhibited LF on uncounted-with-inhibit value 0xC000
    set_env(1, 1, 0, 0, 1, 0, 16'hC000, 0, 0);
    do_req(0, 8'h0A, 0);
    // R3: inhibit with counted word
    set_env(1, 1, 0, 0, 1, 0, 16'h8005, 0, 0);
    do_req(0, 8'h0A, 0);
    // R9: stall mid transfer keeps count
    set_env(1, 1, 0, 0, 1, 0, 16'h8005, 1, 0);
    do_req(0, 8'h44, 0);
    set_env(1, 1, 0, 0, 1, 0, 16'h8005, 0, 1);
    do_req(0, 8'h45, 0);
    // R6: active talker disables monitoring
    set_env(1, 1, 1, 1, 1, 0, 16'h0000, 0, 0);
    do_req(0, 8'h0A, 0);
    // R7: secondary addresses, talk and listen
    set_env(0, 1, 0, 0, 0, 1, 16'h0, 0, 0);
    do_req(1, 8'h07, 0);
    set_env(0, 0, 1, 0, 0, 1, 16'h0, 0, 0);
    do_req(1, 8'hFF, 0);
    set_env(0, 0, 0, 0, 0, 1, 16'h0, 0, 0);
    do_req(1, 8'h03, 0);
    // R8: not listening, still counts
    set_env(0, 1, 0, 0, 1, 0, 16'h0002, 1, 0);
    do_req(0, 8'h55, 0);
    do_req(0, 8'h56, 0);
    // Random mix: R2 R3 R4 R5 R6 R8 R9 R10 R12
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] hd;
      int sel;
      sel = $urandom_range(0, 5);
      case (sel)
        0: hd = 16'hC000;
        1: hd = 16'h8000 | 16'($urandom_range(0, 6));
        2: hd = 16'($urandom_range(0, 6));
        3: hd = 16'($urandom);
        default: hd = 16'h0000 | 16'($urandom_range(1, 4));
      endcase
      set_env($urandom_range(0, 9) > 1, $urandom_range(0, 1), $urandom_range(0, 1),
              $urandom_range(0, 7) == 0, $urandom_range(0, 5) > 0,
              $urandom_range(0, 7) == 0, hd,
              $urandom_range(0, 9) == 0, $urandom_range(0, 15) == 0);
      do_req($urandom_range(0, 7) == 0,
             ($urandom_range(0, 3) == 0) ? 8'h0A : 8'($urandom),
             $urandom_range(0, 9) == 0);
      if ($urandom_range(0, 9) == 0) begin
        @(negedge clk);
        chk("R12", observed() & 21'h4, 21'h0);
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule